// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine with Receive Sum Status

This block sits in a transmit datapath. It takes a frame one byte per cycle, together with three sideband header words. As the bytes arrive it accumulates a ones'-complement 16-bit sum, starting at a per-frame start offset. The bytes are also written into a local frame buffer. After the final byte it adds a per-frame seed, folds the carries and inverts the result. It then replays the buffered frame on its output. When insertion is enabled, the two checksum bytes replace the frame bytes at the per-frame write offset, high byte first. Because the checksum is only known at the end of the frame, nothing is forwarded until the whole frame is held. Frames are limited to `MAX_LEN` bytes.

The transmit path also filters frames. A frame is discarded silently when the transmit enable is low. It is also discarded when both the large-frame mode and the tagged-frame mode are off and its length falls in the band just above a standard frame. This decision uses the configuration sampled on the last byte.

A separate receive-side unit watches a receive byte stream. For each frame it reports a raw folded 16-bit sum of the bytes after the 14-byte link header. The result is presented as status for one cycle.

Top module: `csum_insert_engine`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and `rx_sum_valid` is 0.
- R2: With `hdr_w0[0]`=0, a frame accepted on `in_*` is replayed on `out_*` with the same bytes in the same order. `out_last` is set on its final byte only.
- R3: With `hdr_w0[0]`=1, the value computed is the inverted, fully folded 16-bit ones'-complement sum of two things: the big-endian byte pairs from byte index `hdr_w1[31:16]` to the end of the frame, and the seed `hdr_w2[15:0]`. Its high byte replaces the byte at index `hdr_w1[15:0]` and its low byte replaces the byte at the next index. The header words are sampled together with the first byte of the frame.
- R4: When the summed range has an odd number of bytes, the final byte is the high half of a word whose low half is zero.
- R5: When the start offset is at or beyond the frame length, the checksum is the inverted folded seed alone.
- R6: A checksum byte whose index falls at or beyond the frame end is not emitted. The frame length is unchanged.
- R7: When `cfg_tx_en` is 0 on the last byte of a frame, the frame produces no output.
- R8: When `cfg_jumbo` and `cfg_vlan` are both 0 on the last byte, frames of 1519 to 1522 bytes produce no output. Frames of 1518 or 1523 bytes are still forwarded. Setting either mode bit forwards the 1519 to 1522 byte band.
- R9: `in_ready` is 0 from the cycle after the last input byte until the replay ends. The replay is one unbroken burst of `out_valid`.
- R10: One cycle after `rx_last`, `rx_sum_valid` pulses for one cycle. `rx_sum` then holds the non-inverted folded sum of the big-endian pairs from receive byte index 14 to the end, with an odd final byte padded with a zero low byte.
- R11: A receive frame of 14 bytes or fewer reports `rx_sum` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tx_en | input | 1 | Transmit enable, sampled on last byte |
| cfg_jumbo | input | 1 | Large-frame mode, sampled on last byte |
| cfg_vlan | input | 1 | Tagged-frame mode, sampled on last byte |
| hdr_w0 | input | 32 | Bit 0: checksum insertion enable |
| hdr_w1 | input | 32 | [31:16] start offset, [15:0] write offset |
| hdr_w2 | input | 32 | [15:0] seed |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of input frame |
| in_ready | output | 1 | Engine can accept bytes |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of output frame |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final receive byte |
| rx_sum | output | 16 | Folded receive sum |
| rx_sum_valid | output | 1 | Receive sum status pulse |

## Verification
The assertions assume that the source never offers a byte while `in_ready` is low. They also assume that no frame exceeds `MAX_LEN` bytes, so the index never passes the buffer depth. The stimulus waits for `in_ready` before every frame and keeps frames within the buffer, including the 1519 to 1523 byte band. The header words are held steady for the whole frame, so sampling them on the first byte is never ambiguous.

// File: rtl/csum_pkg.sv
package csum_pkg;
  localparam int SUM_W      = 32;
  localparam int STD_LEN    = 1518;
  localparam int TAGGED_LEN = 1522;

  typedef enum logic [1:0] {ENG_RECV, ENG_CALC, ENG_SEND} eng_state_t;

  // place a byte in the high or low half of a 16-bit word
  function automatic logic [SUM_W-1:0] lane_word(input logic [7:0] b, input logic hi);
    return hi ? {16'h0000, b, 8'h00} : {24'h000000, b};
  endfunction

  // end-around carry fold of a 32-bit sum to 16 bits
  function automatic logic [15:0] fold_sum(input logic [SUM_W-1:0] x);
    logic [16:0] p;
    logic [16:0] q;
    p = {1'b0, x[15:0]} + {1'b0, x[31:16]};
    q = {1'b0, p[15:0]} + {16'h0000, p[16]};
    return q[15:0];
  endfunction
endpackage

// File: rtl/csum_sum_lane.sv
module csum_sum_lane
  import csum_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             first,
  input  logic             take,
  input  logic             hi,
  input  logic [7:0]       data,
  output logic [SUM_W-1:0] acc,
  output logic [SUM_W-1:0] acc_nxt
);
  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] base;

  always_comb begin
    base    = first ? '0 : acc_q;
    acc_nxt = base + (take ? lane_word(data, hi) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_nxt;
  end

  assign acc = acc_q;

  // running sum never wraps within a frame
  assert_lane_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !first) |-> (acc_nxt >= acc_q));
endmodule

// File: rtl/csum_frame_buf.sv
module csum_frame_buf #(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/csum_rx_status.sv
module csum_rx_status
  import csum_pkg::*;
#(
  parameter int HDR_LEN = 14,
  parameter int IDX_W   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic [15:0] rx_sum,
  output logic        rx_sum_valid
);
  localparam logic HDR_PAR = 1'(HDR_LEN % 2);

  logic [IDX_W-1:0] ridx_q;
  logic             r_first, r_take, r_hi;
  logic [SUM_W-1:0] r_acc, r_acc_nxt;
  logic [15:0]      sum_q;
  logic             vld_q;

  assign r_first = (ridx_q == '0);
  assign r_take  = (ridx_q >= IDX_W'(HDR_LEN));
  assign r_hi    = (ridx_q[0] == HDR_PAR);

  csum_sum_lane u_rx_lane (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (rx_valid),
    .first   (r_first),
    .take    (r_take),
    .hi      (r_hi),
    .data    (rx_data),
    .acc     (r_acc),
    .acc_nxt (r_acc_nxt)
  );

  wire unused_rx_acc = ^r_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ridx_q <= '0;
      sum_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= rx_valid && rx_last;
      if (rx_valid) begin
        if (rx_last) begin
          ridx_q <= '0;
          sum_q  <= fold_sum(r_acc_nxt);
        end else if (ridx_q != '1) begin
          ridx_q <= ridx_q + IDX_W'(1);
        end
      end
    end
  end

  assign rx_sum       = sum_q;
  assign rx_sum_valid = vld_q;

  // status appears exactly one cycle after a receive frame ends
  assert_rx_status_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sum_valid |-> $past(rx_valid && rx_last));
endmodule

// File: rtl/csum_insert_engine.sv
module csum_insert_engine
  import csum_pkg::*;
#(
  parameter int MAX_LEN = 2048,
  parameter int RX_HDR  = 14,
  localparam int LW     = $clog2(MAX_LEN + 1),
  localparam int AW     = $clog2(MAX_LEN)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_tx_en,
  input  logic        cfg_jumbo,
  input  logic        cfg_vlan,
  input  logic [31:0] hdr_w0,
  input  logic [31:0] hdr_w1,
  input  logic [31:0] hdr_w2,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic [15:0] rx_sum,
  output logic        rx_sum_valid
);
  eng_state_t       state_q;
  logic [LW-1:0]    idx_q, len_q, rd_q, len_nxt;
  logic [15:0]      start_q, woff_q, seed_q, csum_q;
  logic             ins_q, drop_q;

  // named internal events
  logic             accept, first_byte, frame_end, drop_now, send_end;
  logic [15:0]      start_eff;
  logic             t_take, t_hi;
  logic [SUM_W-1:0] t_acc, t_acc_nxt;
  logic [7:0]       buf_rd;
  logic [7:0]       send_byte;
  logic [16:0]      rd17, w17;

  wire unused_hdr_bits = ^{hdr_w0[31:1], hdr_w2[31:16], t_acc_nxt};

  assign in_ready   = (state_q == ENG_RECV);
  assign accept     = in_ready && in_valid;
  assign first_byte = accept && (idx_q == '0);
  assign frame_end  = accept && in_last;
  assign len_nxt    = idx_q + LW'(1);
  assign drop_now   = !cfg_tx_en ||
                      (!cfg_jumbo && !cfg_vlan &&
                       (32'(len_nxt) > STD_LEN) && (32'(len_nxt) <= TAGGED_LEN));
  assign send_end   = (state_q == ENG_SEND) && (rd_q + LW'(1) == len_q);

  assign start_eff  = (idx_q == '0) ? hdr_w1[31:16] : start_q;
  assign t_take     = (16'(idx_q) >= start_eff);
  assign t_hi       = (idx_q[0] == start_eff[0]);

  csum_sum_lane u_tx_lane (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (accept),
    .first   (idx_q == '0),
    .take    (t_take),
    .hi      (t_hi),
    .data    (in_data),
    .acc     (t_acc),
    .acc_nxt (t_acc_nxt)
  );

  csum_frame_buf #(.DEPTH(MAX_LEN)) u_buf (
    .clk     (clk),
    .wr_en   (accept && (32'(idx_q) < MAX_LEN)),
    .wr_addr (AW'(idx_q)),
    .wr_data (in_data),
    .rd_addr (AW'(rd_q)),
    .rd_data (buf_rd)
  );

  assign rd17 = 17'(rd_q);
  assign w17  = {1'b0, woff_q};

  always_comb begin
    send_byte = buf_rd;
    if (ins_q && (rd17 == w17))               send_byte = csum_q[15:8];
    else if (ins_q && (rd17 == w17 + 17'd1))  send_byte = csum_q[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ENG_RECV;
      idx_q     <= '0;
      len_q     <= '0;
      rd_q      <= '0;
      start_q   <= '0;
      woff_q    <= '0;
      seed_q    <= '0;
      csum_q    <= '0;
      ins_q     <= 1'b0;
      drop_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      unique case (state_q)
        ENG_RECV: begin
          if (first_byte) begin
            ins_q   <= hdr_w0[0];
            start_q <= hdr_w1[31:16];
            woff_q  <= hdr_w1[15:0];
            seed_q  <= hdr_w2[15:0];
          end
          if (accept) begin
            if (frame_end) begin
              idx_q   <= '0;
              len_q   <= len_nxt;
              drop_q  <= drop_now;
              state_q <= ENG_CALC;
            end else begin
              idx_q <= len_nxt;
            end
          end
        end
        ENG_CALC: begin
          csum_q  <= ~fold_sum(t_acc + {16'h0000, seed_q});
          rd_q    <= '0;
          state_q <= drop_q ? ENG_RECV : ENG_SEND;
        end
        ENG_SEND: begin
          out_valid <= 1'b1;
          out_data  <= send_byte;
          out_last  <= send_end;
          rd_q      <= rd_q + LW'(1);
          if (send_end) state_q <= ENG_RECV;
        end
        default: state_q <= ENG_RECV;
      endcase
    end
  end

  csum_rx_status #(.HDR_LEN(RX_HDR)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_last      (rx_last),
    .rx_sum       (rx_sum),
    .rx_sum_valid (rx_sum_valid)
  );

  // input assumption: no byte offered while busy
  assert_busy_no_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !in_valid);
  // input assumption: frame fits the buffer
  assert_len_in_buf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (32'(idx_q) < MAX_LEN));
  // replay is an unbroken burst
  assert_burst_contig_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);
  assert_burst_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> !out_valid);
  // a discarded frame emits nothing
  assert_drop_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ENG_CALC) && drop_q) |=> (!out_valid && in_ready));
endmodule

// File: tb/tb_csum_insert_engine.sv
module tb_csum_insert_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_tx_en = 1'b1, cfg_jumbo = 1'b0, cfg_vlan = 1'b0;
  logic [31:0] hdr_w0 = '0, hdr_w1 = '0, hdr_w2 = '0;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_last;
  logic [7:0]  out_data;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [15:0] rx_sum;
  logic        rx_sum_valid;

  int checks = 0, fails = 0;
  int ocnt = 0, base = 0;
  logic [7:0] frm  [2048];
  logic [7:0] expf [2048];
  logic [7:0] outb [2048];

  always #(CLK_PERIOD/2) clk = ~clk;

  csum_insert_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_jumbo(cfg_jumbo),
    .cfg_vlan(cfg_vlan), .hdr_w0(hdr_w0), .hdr_w1(hdr_w1), .hdr_w2(hdr_w2),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_sum(rx_sum), .rx_sum_valid(rx_sum_valid)
  );

  always @(negedge clk) begin
    if (out_valid) begin
      if (ocnt - base < 2048) outb[ocnt - base] = out_data;
      ocnt = ocnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int fold_ref(input longint s);
    longint v = s;
    while (v > 65535) v = (v & 65535) + (v >> 16);
    return int'(v);
  endfunction

  function automatic int pair_sum(input int len, input int st);
    longint s = 0;
    for (int i = st; i < len; i += 2)
      s += longint'(frm[i]) * 256 + ((i + 1 < len) ? longint'(frm[i+1]) : 0);
    return fold_ref(s);
  endfunction

  task automatic fill(input int len, input int k);
    for (int i = 0; i < len; i++) frm[i] = 8'((i * 37 + k * 11 + (i >> 3)) & 255);
  endtask

  // send one frame, compare replay with the model
  task automatic run_tx(input string req, input int len, input bit ins,
                        input int st, input int wo, input int seed, input bit fwd);
    int ck, got, bad, last_seen;
    ck = 16'(~fold_ref(longint'(pair_sum(len, st)) + (seed & 65535)));
    for (int i = 0; i < len; i++) expf[i] = frm[i];
    if (ins) begin
      if (wo < len)     expf[wo]   = 8'(ck >> 8);
      if (wo + 1 < len) expf[wo+1] = 8'(ck);
    end
    while (!in_ready) @(negedge clk);
    base   = ocnt;
    hdr_w0 = {31'h0, ins};
    hdr_w1 = {16'(st), 16'(wo)};
    hdr_w2 = {16'hA5A5, 16'(seed)};
    last_seen = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = frm[i]; in_last = (i == len - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk(in_ready == 1'b0, "R9", "busy after last byte", int'(in_ready), 0);
    while (!in_ready) begin
      @(negedge clk);
      if (out_valid && out_last) last_seen++;
    end
    repeat (3) begin
      @(negedge clk);
      if (out_valid && out_last) last_seen++;
    end
    got = ocnt - base;
    if (!fwd) begin
      chk(got == 0, req, "dropped frame emitted bytes", got, 0);
    end else begin
      bad = 0;
      for (int i = 0; i < len && i < got; i++) if (outb[i] !== expf[i]) bad++;
      chk(got == len, req, "replay length", got, len);
      chk(bad == 0 && last_seen == 1, req, "replay bytes/last", bad, 0);
    end
  endtask

  task automatic run_rx(input string req, input int len);
    int ex;
    ex = (len > 14) ? pair_sum(len, 14) : 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = frm[i]; rx_last = (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    chk(rx_sum_valid == 1'b1, req, "status pulse", int'(rx_sum_valid), 1);
    chk(int'(rx_sum) == ex, req, "rx sum", int'(rx_sum), ex);
    @(negedge clk);
    chk(rx_sum_valid == 1'b0, req, "pulse one cycle", int'(rx_sum_valid), 0);
  endtask

  task automatic test_reset();
    chk(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
    chk(rx_sum_valid == 1'b0, "R1", "rx_sum_valid", int'(rx_sum_valid), 0);
  endtask

  task automatic test_insert();
    fill(60, 1); run_tx("R2", 60, 1'b0, 0, 0, 0, 1'b1);
    fill(64, 2); run_tx("R3", 64, 1'b1, 34, 50, 16'h1234, 1'b1);
    fill(64, 3); run_tx("R3", 64, 1'b1, 14, 10, 16'hFFFF, 1'b1);
    fill(61, 4); run_tx("R4", 61, 1'b1, 20, 24, 16'h0042, 1'b1);
    fill(61, 5); run_tx("R4", 61, 1'b1, 13, 2, 16'h0000, 1'b1);
    fill(40, 6); run_tx("R5", 40, 1'b1, 40, 4, 16'hBEEF, 1'b1);
    fill(40, 7); run_tx("R6", 40, 1'b1, 0, 39, 16'h0101, 1'b1);
    fill(40, 8); run_tx("R6", 40, 1'b1, 0, 100, 16'h0101, 1'b1);
  endtask

  task automatic test_drop();
    cfg_tx_en = 1'b0;
    fill(50, 9); run_tx("R7", 50, 1'b1, 0, 0, 0, 1'b0);
    cfg_tx_en = 1'b1;
    fill(1523, 10);
    run_tx("R8", 1518, 1'b0, 0, 0, 0, 1'b1);
    run_tx("R8", 1519, 1'b0, 0, 0, 0, 1'b0);
    run_tx("R8", 1522, 1'b0, 0, 0, 0, 1'b0);
    run_tx("R8", 1523, 1'b1, 14, 16, 16'h7777, 1'b1);
    cfg_vlan = 1'b1;
    run_tx("R8", 1520, 1'b0, 0, 0, 0, 1'b1);
    cfg_vlan = 1'b0; cfg_jumbo = 1'b1;
    run_tx("R8", 1521, 1'b0, 0, 0, 0, 1'b1);
    cfg_jumbo = 1'b0;
  endtask

  task automatic test_rx();
    fill(64, 11); run_rx("R10", 64);
    fill(47, 12); run_rx("R10", 47);
    fill(14, 13); run_rx("R11", 14);
    fill(9, 14);  run_rx("R11", 9);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_insert();
    test_drop();
    test_rx();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule